// File: doc/BRIEF.md
# SuperSpeed PHY Calibration Write Sequencer

This block programs three tuning registers inside a SuperSpeed PHY through a control-port master. A one-cycle trigger, typically raised when the controller enters host mode, starts the run. The block then issues three register writes in a fixed order: loss-of-signal threshold, transmit boost, and receiver-detect measurement time. It builds each data word from constants. For the last word it also uses a reference-clock code that it latches at the moment of the trigger.

Each write is offered to the master as a held request, with address and data. The block waits for the master's one-cycle completion strobe, which carries an error flag, before it moves to the next write. A failed first or second write ends the run at once. When the run ends, the block drops its busy flag and emits a one-cycle completion pulse. That pulse carries the error flag of the last write that was performed.

Top module: `ss_cal_seq`

## Requirements
- R1: One cycle after `start` is sampled high while idle, `busy` and `wr_req` are high and the request carries address 0x0015 with data 0xA409.
- R2: After the first write completes without error, the request carries address 0x0012 with data 0xA000 in the next cycle.
- R3: After the second write completes without error, the request carries address 0x1010 with data equal to the measurement value shifted left by 4. The value depends on the clock code: codes 0 and 1 (19.2 and 20 MHz) give 0x4 (data 0x0040), code 3 (50 MHz) gives 0x20 (data 0x0200), and code 2 (24 MHz) and codes 4 to 7 give 0x8 (data 0x0080).
- R4: The clock code used for the third write is the value of `ref_sel` sampled with the accepted trigger. Later changes of `ref_sel` have no effect on the run.
- R5: While a write is outstanding (`wr_req` high and `wr_done` low), the address and data are held unchanged into the next cycle.
- R6: A `wr_done` with `wr_err` high on the first or second write ends the run: `wr_req` is low in the next cycle and no later write is requested.
- R7: The cycle after the final `wr_done` of a run, `seq_done` is high for exactly one cycle and `busy` is low. `seq_err` equals the `wr_err` of that final write, including when the error is on the third write.
- R8: `start` while `busy` is high is ignored.
- R9: `wr_done` while no write is requested is ignored: no state change and no `seq_done`.
- R10: While reset is asserted and after reset, `busy`, `wr_req` and `seq_done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Trigger pulse that begins a calibration run |
| ref_sel | input | 3 | Reference clock code (0=19.2, 1=20, 2=24, 3=50 MHz) |
| busy | output | 1 | High while a run is in progress |
| wr_req | output | 1 | Write request to the control-port master, held until done |
| wr_addr | output | 16 | Register address of the current write |
| wr_data | output | 16 | Data word of the current write |
| wr_done | input | 1 | One-cycle completion strobe from the master |
| wr_err | input | 1 | Error flag, valid with `wr_done` |
| seq_done | output | 1 | One-cycle pulse at the end of a run |
| seq_err | output | 1 | Error status of the run, valid with `seq_done` |

## Verification
The bench runs all eight clock codes. A design that decodes the code wrongly would put the wrong measurement word on the third write, and codes above 3 would show it by missing the default. Errors are injected on each of the three writes: an early-abort bug would issue a stray following write, and a bug in the final status would report success after the third write failed. The bench also changes `ref_sel` and pulses `start` mid-run, which a design that resamples either would turn into a changed third word or a restarted sequence. A stray `wr_done` while idle catches a design that advances or ends a run it never started.

// File: rtl/ss_cal_seq.sv
module ss_cal_seq #(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int SW       = 3,
  parameter int SEL_19M2 = 0,
  parameter int SEL_20M  = 1,
  parameter int SEL_24M  = 2,
  parameter int SEL_50M  = 3,
  parameter int MEAS_LSB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [SW-1:0] ref_sel,
  output logic          busy,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  input  logic          wr_done,
  input  logic          wr_err,
  output logic          seq_done,
  output logic          seq_err
);
  localparam logic [AW-1:0] LOS_ADDR   = AW'(16'h0015);
  localparam logic [AW-1:0] BOOST_ADDR = AW'(16'h0012);
  localparam logic [AW-1:0] RXDET_ADDR = AW'(16'h1010);
  localparam logic [DW-1:0] LOS_WORD   = DW'((5 << 13) | (1 << 10) | 9);
  localparam logic [DW-1:0] BOOST_WORD = DW'(5 << 13);
  localparam logic [1:0]    LAST_STEP  = 2'd2;

  logic          busy_q, done_q, err_q;
  logic [1:0]    step_q;
  logic [SW-1:0] sel_q;
  logic [7:0]    meas;
  logic          last;

  assign last = (step_q == LAST_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      step_q <= 2'd0;
      sel_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        if (wr_done) begin
          if (wr_err || last) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            err_q  <= wr_err;
          end else begin
            step_q <= step_q + 2'd1;
          end
        end
      end else if (start) begin
        busy_q <= 1'b1;
        step_q <= 2'd0;
        sel_q  <= ref_sel;
      end
    end
  end

  always_comb begin
    case (sel_q)
      SW'(SEL_50M):                 meas = 8'h20;
      SW'(SEL_19M2), SW'(SEL_20M):  meas = 8'h04;
      SW'(SEL_24M):                 meas = 8'h08;
      default:                      meas = 8'h08;
    endcase
  end

  always_comb begin
    case (step_q)
      2'd0:    begin wr_addr = LOS_ADDR;   wr_data = LOS_WORD;   end
      2'd1:    begin wr_addr = BOOST_ADDR; wr_data = BOOST_WORD; end
      default: begin wr_addr = RXDET_ADDR; wr_data = DW'(meas) << MEAS_LSB; end
    endcase
  end

  assign busy     = busy_q;
  assign wr_req   = busy_q;
  assign seq_done = done_q;
  assign seq_err  = err_q;
endmodule

// File: rtl/ss_cal_seq_chk.sv
module ss_cal_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        wr_req,
  input logic [15:0] wr_addr,
  input logic [15:0] wr_data,
  input logic        wr_done,
  input logic        wr_err,
  input logic        seq_done
);
  a_r1_first_write: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> wr_req && wr_addr == 16'h0015 && wr_data == 16'hA409);

  a_r2_second_after_first: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && wr_done && !wr_err && wr_addr == 16'h0015 |=> wr_req && wr_addr == 16'h0012);

  a_r3_third_after_second: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && wr_done && !wr_err && wr_addr == 16'h0012 |=> wr_req && wr_addr == 16'h1010);

  a_r5_hold_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_done |=> wr_req && $stable(wr_addr) && $stable(wr_data));

  a_r6_abort_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && wr_done && wr_err |=> !wr_req && seq_done);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> !busy);

  a_r9_idle_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start && wr_done |=> !busy && !seq_done);
endmodule

bind ss_cal_seq ss_cal_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .wr_req(wr_req),
  .wr_addr(wr_addr), .wr_data(wr_data), .wr_done(wr_done), .wr_err(wr_err),
  .seq_done(seq_done)
);

// File: tb/ss_cal_seq_test.sv
module ss_cal_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  ref_sel = 3'd0;
  logic        wr_done = 1'b0;
  logic        wr_err = 1'b0;
  logic        busy, wr_req, seq_done, seq_err;
  logic [15:0] wr_addr, wr_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ss_cal_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_sel(ref_sel),
    .busy(busy), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_done(wr_done), .wr_err(wr_err), .seq_done(seq_done), .seq_err(seq_err)
  );

  // Behavioural reference model
  bit m_busy = 0, m_done = 0, m_err = 0;
  int m_step = 0, m_sel = 0;
  bit prev_busy = 0;
  int prev_step = 0;

  function automatic logic [15:0] exp_addr(int s);
    if (s == 0) return 16'h0015;
    if (s == 1) return 16'h0012;
    return 16'h1010;
  endfunction

  function automatic logic [15:0] exp_data(int s, int sel);
    int t;
    if (s == 0) return 16'hA409;
    if (s == 1) return 16'hA000;
    if (sel == 3) t = 32;
    else if (sel == 0 || sel == 1) t = 4;
    else t = 8;
    return 16'(t * 16);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    prev_busy = m_busy;
    prev_step = m_step;
    m_done = 0;
    if (!rst_n) begin
      m_busy = 0; m_err = 0; m_step = 0; m_sel = 0; prev_busy = 0;
    end else if (m_busy) begin
      if (wr_done) begin
        if (wr_err || m_step == 2) begin
          m_busy = 0; m_done = 1; m_err = wr_err;
        end else m_step++;
      end
    end else if (start) begin
      m_busy = 1; m_step = 0; m_sel = int'(ref_sel);
    end
  end

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    string tb_tag, dtag;
    if (!finished) begin
      cycles++;
      tb_tag = !rst_n ? "R10" : (start && prev_busy) ? "R8" : (wr_done && !m_busy) ? "R9" : "R7";
      check(busy === m_busy, tb_tag, "busy", int'(busy), int'(m_busy));
      check(wr_req === m_busy, m_busy ? "R6" : tb_tag, "wr_req", int'(wr_req), int'(m_busy));
      check(seq_done === m_done, tb_tag, "seq_done", int'(seq_done), int'(m_done));
      if (m_done) check(seq_err === m_err, "R7", "seq_err", int'(seq_err), int'(m_err));
      if (m_busy) begin
        if (prev_busy && prev_step == m_step) dtag = "R5";
        else if (m_step == 0) dtag = "R1";
        else if (m_step == 1) dtag = "R2";
        else dtag = (m_sel != int'(ref_sel)) ? "R4" : "R3";
        check(wr_addr === exp_addr(m_step), dtag, "wr_addr", int'(wr_addr), int'(exp_addr(m_step)));
        check(wr_data === exp_data(m_step, m_sel), dtag, "wr_data", int'(wr_data),
              int'(exp_data(m_step, m_sel)));
      end
    end
  end

  // Runs one sequence; emask bit w injects an error on write w.
  task automatic run_seq(input logic [2:0] sel, input int lat, input logic [2:0] emask, input bit poke);
    @(negedge clk); start = 1; ref_sel = sel;
    @(negedge clk); start = 0;
    for (int w = 0; w < 3; w++) begin
      for (int c = 0; c < lat; c++) begin
        @(negedge clk);
        if (poke) begin start = 1; ref_sel = ~sel; end  // R4, R8 stimulus
      end
      wr_done = 1; wr_err = emask[w];
      @(negedge clk);
      wr_done = 0; wr_err = 0; start = 0; ref_sel = sel;
      if (emask[w]) break;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;  // R10 checked by the per-cycle compare during and after reset
    repeat (2) @(negedge clk);
    for (int s = 0; s < 8; s++) run_seq(3'(s), s % 3, 3'b000, 0);  // R1 R2 R3
    run_seq(3'd3, 1, 3'b001, 0);  // R6 error on first write
    run_seq(3'd0, 2, 3'b010, 0);  // R6 error on second write
    run_seq(3'd1, 0, 3'b100, 0);  // R7 error on final write
    run_seq(3'd3, 3, 3'b000, 1);  // R4 R8 changes mid-run
    run_seq(3'd5, 2, 3'b000, 1);
    @(negedge clk); wr_done = 1; wr_err = 1;  // R9 stray completion while idle
    @(negedge clk); wr_done = 0; wr_err = 0;
    repeat (3) @(negedge clk);
    run_seq(3'd2, 0, 3'b000, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule